// File: doc/BRIEF.md
# Dual Oscillator Clock-Stop Monitor

This block runs from a free-running internal RC reference clock and watches two external oscillator clocks, called main and sub. Each observed clock toggles a flag in its own domain. The toggle is brought into the RC domain through a synchronizer, and every toggle it detects restarts a per-channel window counter. When an enabled channel goes a whole window of RC cycles without a detected edge, its sticky missing flag sets. Software clears the flag by writing a one to it.

When a flag sets, the block can also issue a single-cycle clock-stop reset request. It does so only when the reset function is enabled and the failed oscillator is the selected source of system clock 1, system clock 2 or the watchdog timer. The same event sets a reset-cause bit, and that bit drives an output which tells the clock switch to fall back to the RC clock. The reset enable is write-protected: a write changes it only while system clock 1 runs from the RC clock.

Top module: `clkmon_top`

## Requirements
- R1: After reset, the control register (address 0) and the status register (address 1) read as zero, and both `stop_rst_req` and `force_rc` are low.
- R2: For the main channel, control bit 1 chooses the window length: 0 selects a long window of WIN_SLOW (default 7) RC cycles and 1 selects a short window of WIN_FAST (default 3). Suppose the main clock runs with a period of T RC cycles. The main missing flag (status bit 0) then sets exactly when T is greater than the selected window.
- R3: The sub channel behaves the same way. Its window is chosen by control bit 2 and its flag is status bit 1.
- R4: A channel's flag cannot set while its enable input is low, or while `rc_en` is low. It sets once both are high and the channel's clock stays stopped.
- R5: The missing flags are sticky. Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged.
- R6: Control bit 0 (the reset enable) follows a write only when `sys1_sel` is 2'b00 (RC). Otherwise that bit keeps its value. Bits 1 and 2 follow every write.
- R7: `stop_rst_req` pulses high for exactly one cycle when a flag sets, provided the reset enable is 1 and the channel code (main 2'b01, sub 2'b10) matches any of `sys1_sel`, `sys2_sel` or `wdt_sel`. In all other cases it stays low.
- R8: The request is not repeated while the flag stays set. It can occur again only after the flag has been cleared and the failure has been detected again.
- R9: A request sets status bit 2 (the reset cause) and drives `force_rc` high. Both stay set until software writes a 1 to status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | RC reference clock |
| rc_rst_n | input | 1 | Active-low asynchronous reset |
| rc_en | input | 1 | RC oscillator enabled; detection runs only while this is high |
| main_clk | input | 1 | Observed main oscillator clock |
| main_en | input | 1 | Main oscillator enabled |
| sub_clk | input | 1 | Observed sub oscillator clock |
| sub_en | input | 1 | Sub oscillator enabled |
| sys1_sel | input | 2 | Source of system clock 1 (00 RC, 01 main, 10 sub, 11 other) |
| sys2_sel | input | 2 | Source of system clock 2, same encoding |
| wdt_sel | input | 2 | Source of the watchdog clock, same encoding |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 control, 1 status) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| stop_rst_req | output | 1 | One-cycle clock-stop reset request |
| force_rc | output | 1 | Forces the clock selection back to RC while the cause bit is set |

## Verification
The case that is hardest to reach from the ports is the exact boundary between a slow but live oscillator and a dead one: a period one RC cycle longer or shorter than the window. To reach it, the bench drives each observed clock at a whole number of RC periods, with its edges offset from the RC edges, and sweeps that period across both window settings on both channels. It clears the flags once the channel has settled and then compares each flag with the period-against-window rule. Request gating is exercised by repeating a single failure under different source selections and enable settings, and by counting the request pulses.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
   localparam int NUM_CH     = 2;
   localparam int ADDR_CTRL  = 0;
   localparam int ADDR_STAT  = 1;
   localparam int CTRL_RSTEN = 0;
   localparam int CTRL_FAST0 = 1;            // fast-window bit of channel 0; channel i at CTRL_FAST0+i
   localparam int STAT_MISS0 = 0;            // missing flag of channel i at STAT_MISS0+i
   localparam int STAT_CAUSE = NUM_CH;

   typedef enum logic [1:0] {
      SRC_RC    = 2'b00,
      SRC_MAIN  = 2'b01,
      SRC_SUB   = 2'b10,
      SRC_OTHER = 2'b11
   } clk_src_e;

   function automatic logic [1:0] ch_code(input int ch);
      return 2'(ch + 1);
   endfunction
endpackage

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic obs_clk,
   input  logic rst_n,
   input  logic rc_clk,
   output logic edge_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("clkmon_edge_sync: SYNC_STAGES must be at least 2");
   end

   logic                   tog_q;
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   // toggles once per rising edge of the observed clock
   always_ff @(posedge obs_clk or negedge rst_n) begin
      if (!rst_n) tog_q <= 1'b0;
      else        tog_q <= ~tog_q;
   end

   always_ff @(posedge rc_clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], tog_q};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign edge_o = sync_q[SYNC_STAGES-1] ^ prev_q;
endmodule

// File: rtl/clkmon_window.sv
module clkmon_window #(
   parameter int WIN_SLOW = 7,
   parameter int WIN_FAST = 3,
   localparam int CNT_W   = $clog2(WIN_SLOW + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic fast,
   input  logic edge_i,
   input  logic clr_i,
   output logic flag_o,
   output logic set_evt_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   logic             hit;

   assign limit     = fast ? CNT_W'(WIN_FAST) : CNT_W'(WIN_SLOW);
   assign hit       = active && (cnt_q >= limit);
   assign set_evt_o = hit && !flag_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_o <= 1'b0;
      end else begin
         if (!active || edge_i) cnt_q <= '0;
         else if (cnt_q < limit) cnt_q <= cnt_q + 1'b1;
         flag_o <= hit | (flag_o & ~clr_i);
      end
   end
endmodule

// File: rtl/clkmon_regs.sv
module clkmon_regs
   import clkmon_pkg::*;
#(
   parameter int ADDR_W = 1,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              sys1_is_rc,
   input  logic [NUM_CH-1:0] miss,
   input  logic              req_evt,
   output logic              rst_en,
   output logic [NUM_CH-1:0] fast,
   output logic [NUM_CH-1:0] miss_clr,
   output logic              cause
);
   logic wr_ctrl, wr_stat;
   logic [DATA_W-1:0] ctrl_img, stat_img;

   assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
   assign wr_stat = bus_wr && (bus_addr == ADDR_W'(ADDR_STAT));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_clr
      assign miss_clr[i] = wr_stat && bus_wdata[STAT_MISS0+i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_en <= 1'b0;
         fast   <= '0;
         cause  <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            if (sys1_is_rc) rst_en <= bus_wdata[CTRL_RSTEN];
            fast <= bus_wdata[CTRL_FAST0 +: NUM_CH];
         end
         cause <= req_evt | (cause & ~(wr_stat && bus_wdata[STAT_CAUSE]));
      end
   end

   always_comb begin
      ctrl_img = '0;
      ctrl_img[CTRL_RSTEN] = rst_en;
      ctrl_img[CTRL_FAST0 +: NUM_CH] = fast;
      stat_img = '0;
      stat_img[STAT_MISS0 +: NUM_CH] = miss;
      stat_img[STAT_CAUSE] = cause;
   end

   assign bus_rdata = (bus_addr == ADDR_W'(ADDR_CTRL)) ? ctrl_img : stat_img;
endmodule

// File: rtl/clkmon_top.sv
module clkmon_top
   import clkmon_pkg::*;
#(
   parameter int WIN_SLOW    = 7,
   parameter int WIN_FAST    = 3,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 1,
   parameter int DATA_W      = 8
) (
   input  logic              rc_clk,
   input  logic              rc_rst_n,
   input  logic              rc_en,
   input  logic              main_clk,
   input  logic              main_en,
   input  logic              sub_clk,
   input  logic              sub_en,
   input  logic [1:0]        sys1_sel,
   input  logic [1:0]        sys2_sel,
   input  logic [1:0]        wdt_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              stop_rst_req,
   output logic              force_rc
);
   if (WIN_FAST < 1 || WIN_FAST >= WIN_SLOW) begin : g_bad_win
      $error("clkmon_top: need 1 <= WIN_FAST < WIN_SLOW");
   end
   if (DATA_W < NUM_CH + 2) begin : g_bad_dw
      $error("clkmon_top: DATA_W too small for the register fields");
   end

   logic [NUM_CH-1:0] obs_clk, ch_en, edge_det, fast, miss_clr, miss_q, set_evt, in_use;
   logic rst_en, cause, req_d;
   clk_src_e s1, s2, sw;

   assign obs_clk = {sub_clk, main_clk};
   assign ch_en   = {sub_en, main_en};
   assign s1 = clk_src_e'(sys1_sel);
   assign s2 = clk_src_e'(sys2_sel);
   assign sw = clk_src_e'(wdt_sel);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      clkmon_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
         .obs_clk (obs_clk[i]),
         .rst_n   (rc_rst_n),
         .rc_clk  (rc_clk),
         .edge_o  (edge_det[i])
      );
      clkmon_window #(.WIN_SLOW(WIN_SLOW), .WIN_FAST(WIN_FAST)) u_win (
         .clk       (rc_clk),
         .rst_n     (rc_rst_n),
         .active    (rc_en && ch_en[i]),
         .fast      (fast[i]),
         .edge_i    (edge_det[i]),
         .clr_i     (miss_clr[i]),
         .flag_o    (miss_q[i]),
         .set_evt_o (set_evt[i])
      );
      assign in_use[i] = (s1 == ch_code(i)) || (s2 == ch_code(i)) || (sw == ch_code(i));
   end

   assign req_d = rst_en && |(set_evt & in_use);

   clkmon_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk        (rc_clk),
      .rst_n      (rc_rst_n),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .sys1_is_rc (s1 == SRC_RC),
      .miss       (miss_q),
      .req_evt    (req_d),
      .rst_en     (rst_en),
      .fast       (fast),
      .miss_clr   (miss_clr),
      .cause      (cause)
   );

   always_ff @(posedge rc_clk or negedge rc_rst_n) begin
      if (!rc_rst_n) stop_rst_req <= 1'b0;
      else           stop_rst_req <= req_d;
   end

   assign force_rc = cause;
endmodule

// File: rtl/clkmon_top_sva.sv
module clkmon_top_sva #(
   parameter int ADDR_W = 1,
   parameter int DATA_W = 8
) (
   input logic              rc_clk,
   input logic              rc_rst_n,
   input logic              rc_en,
   input logic [1:0]        sys1_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [1:0]        miss_q,
   input logic              rst_en,
   input logic              stop_rst_req,
   input logic              force_rc
);
   logic stat_wr;
   assign stat_wr = bus_wr && (bus_addr == ADDR_W'(1));

   p_pulse_r7: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
      stop_rst_req |=> !stop_rst_req);
   p_req_needs_flag_r7: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
      stop_rst_req |-> (miss_q != 2'b00));
   p_req_needs_en_r7: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
      stop_rst_req |-> $past(rst_en));
   p_cause_r9: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
      stop_rst_req |-> force_rc);
   p_cause_clear_r9: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
      $fell(force_rc) |-> $past(stat_wr && bus_wdata[2]));
   p_rc_off_r4: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
      !rc_en |=> ((miss_q & ~$past(miss_q)) == 2'b00));
   p_sticky_main_r5: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
      $fell(miss_q[0]) |-> $past(stat_wr && bus_wdata[0]));
   p_sticky_sub_r5: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
      $fell(miss_q[1]) |-> $past(stat_wr && bus_wdata[1]));
   p_protect_r6: assert property (@(posedge rc_clk) disable iff (!rc_rst_n)
      !$stable(rst_en) |-> $past(sys1_sel == 2'b00));
endmodule

bind clkmon_top clkmon_top_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
   .rc_clk       (rc_clk),
   .rc_rst_n     (rc_rst_n),
   .rc_en        (rc_en),
   .sys1_sel     (sys1_sel),
   .bus_wr       (bus_wr),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .miss_q       (miss_q),
   .rst_en       (rst_en),
   .stop_rst_req (stop_rst_req),
   .force_rc     (force_rc)
);

// File: tb/clkmon_top_tb_top.sv
`timescale 1ns/1ps
module clkmon_top_tb_top;
   localparam int WS = 7;
   localparam int WF = 3;

   logic rc_clk = 1'b0, rc_rst_n = 1'b0, rc_en = 1'b1;
   logic main_clk = 1'b0, sub_clk = 1'b0, main_en = 1'b0, sub_en = 1'b0;
   logic [1:0] sys1_sel = 2'b00, sys2_sel = 2'b00, wdt_sel = 2'b00;
   logic bus_wr = 1'b0;
   logic [0:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic stop_rst_req, force_rc;
   int main_per = 0, sub_per = 0;
   int n_chk = 0, n_fail = 0, req_cnt = 0;

   clkmon_top #(.WIN_SLOW(WS), .WIN_FAST(WF)) dut_i (
      .rc_clk(rc_clk), .rc_rst_n(rc_rst_n), .rc_en(rc_en),
      .main_clk(main_clk), .main_en(main_en), .sub_clk(sub_clk), .sub_en(sub_en),
      .sys1_sel(sys1_sel), .sys2_sel(sys2_sel), .wdt_sel(wdt_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .stop_rst_req(stop_rst_req), .force_rc(force_rc));

   always #10 rc_clk = ~rc_clk;   // 50 MHz; rising edges at 10, 30, ...

   // observed clocks: period of N RC cycles, edges at 3 ns past a multiple of 10 ns
   initial begin
      #3;
      forever begin
         if (main_per == 0) begin main_clk = 1'b0; #10; end
         else begin main_clk = 1'b1; #(main_per*10); main_clk = 1'b0; #(main_per*10); end
      end
   end
   initial begin
      #3;
      forever begin
         if (sub_per == 0) begin sub_clk = 1'b0; #10; end
         else begin sub_clk = 1'b1; #(sub_per*10); sub_clk = 1'b0; #(sub_per*10); end
      end
   end

   always @(negedge rc_clk) if (rc_rst_n && stop_rst_req) req_cnt++;

   task automatic chk(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge rc_clk);
      bus_wr = 1'b1; bus_addr = 1'(addr); bus_wdata = 8'(data);
      @(negedge rc_clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int addr, output int data);
      @(negedge rc_clk);
      bus_addr = 1'(addr);
      #1 data = int'(bus_rdata);
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge rc_clk);
   endtask

   initial begin
      #(200000*20);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int v;
      cyc(3);
      rc_rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      rd(0, v); chk(v, 0, "R1 control after reset");
      rd(1, v); chk(v, 0, "R1 status after reset");
      chk(int'(stop_rst_req), 0, "R1 request after reset");
      chk(int'(force_rc), 0, "R1 force_rc after reset");

      // R2 / R3 sweep over period, window choice and channel
      for (int c = 0; c < 2; c++)
         for (int s = 0; s < 2; s++)
            for (int t = 2; t <= 10; t++) begin
               int lim;
               lim = (s == 1) ? WF : WS;
               wr(0, s << (1 + c));
               if (c == 0) begin main_per = t; main_en = 1'b1; end
               else        begin sub_per  = t; sub_en  = 1'b1; end
               cyc(3*t + 10);
               wr(1, 3);
               cyc(4*t + 12);
               rd(1, v);
               if (c == 0) begin
                  chk((v >> 0) & 1, int'(t > lim), $sformatf("R2 main flag sel=%0d T=%0d", s, t));
                  chk((v >> 1) & 1, 0, "R4 sub flag while sub disabled");
               end else begin
                  chk((v >> 1) & 1, int'(t > lim), $sformatf("R3 sub flag sel=%0d T=%0d", s, t));
                  chk((v >> 0) & 1, 0, "R4 main flag while main disabled");
               end
               main_en = 1'b0; sub_en = 1'b0; main_per = 0; sub_per = 0;
               cyc(2);
               wr(1, 3);
            end

      // R4 gating by enables
      wr(0, 0); wr(1, 7);
      main_per = 0; main_en = 1'b0; rc_en = 1'b1;
      cyc(20); rd(1, v); chk(v & 1, 0, "R4 main disabled, stopped");
      main_en = 1'b1; rc_en = 1'b0;
      cyc(20); rd(1, v); chk(v & 1, 0, "R4 rc_en low, stopped");
      rc_en = 1'b1;
      cyc(20); rd(1, v); chk(v & 1, 1, "R4 enabled, stopped");

      // R5 sticky and write-one-to-clear
      main_en = 1'b0;
      wr(1, 0); rd(1, v); chk(v & 1, 1, "R5 write 0 keeps flag");
      wr(1, 1); rd(1, v); chk(v & 1, 0, "R5 write 1 clears flag");

      // R6 write protection of the reset enable
      sys1_sel = 2'b01;
      wr(0, 1); rd(0, v); chk(v & 1, 0, "R6 enable write ignored off RC");
      wr(0, 2); rd(0, v); chk(v, 2, "R6 window bit written off RC");
      sys1_sel = 2'b00;
      wr(0, 1); rd(0, v); chk(v, 1, "R6 enable written on RC");
      sys1_sel = 2'b10;
      wr(0, 0); rd(0, v); chk(v & 1, 1, "R6 disable ignored off RC");
      sys1_sel = 2'b00;

      // R7 / R9 request when main is in use
      sys2_sel = 2'b01; wdt_sel = 2'b00;
      req_cnt = 0;
      main_en = 1'b1;
      cyc(25);
      chk(req_cnt, 1, "R7 one request pulse, main in use");
      chk(int'(force_rc), 1, "R9 force_rc after request");
      rd(1, v); chk((v >> 2) & 1, 1, "R9 cause bit set");
      cyc(30);
      chk(req_cnt, 1, "R8 no repeat while flag set");
      main_en = 1'b0; wr(1, 1); main_en = 1'b1;
      cyc(25);
      chk(req_cnt, 2, "R8 repeat after clear and new failure");
      wr(1, 4);
      rd(1, v); chk((v >> 2) & 1, 0, "R9 cause cleared");
      chk(int'(force_rc), 0, "R9 force_rc cleared");

      // R7 not in use, then through the watchdog, then enable off
      main_en = 1'b0; wr(1, 3);
      sys2_sel = 2'b10; wdt_sel = 2'b11;
      req_cnt = 0; main_en = 1'b1; cyc(25);
      chk(req_cnt, 0, "R7 no request when main unused");
      main_en = 1'b0; wr(1, 3);
      wdt_sel = 2'b01; main_en = 1'b1; cyc(25);
      chk(req_cnt, 1, "R7 request via watchdog source");
      main_en = 1'b0; wr(1, 7);
      wr(0, 0); req_cnt = 0;
      main_en = 1'b1; cyc(25);
      chk(req_cnt, 0, "R7 no request with reset disabled");
      chk(int'(force_rc), 0, "R9 no cause with reset disabled");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule